// File: doc/BRIEF.md
# Isochronous DMA Bus-Request Controller

This block decides when the isochronous transmit engine and the isochronous receive engine should ask for the host bus, and how many quadlets each granted transaction may move. A 16-bit control word holds four 4-bit codes: a maximum-burst code for each engine and a request-threshold code for each engine. Every code n stands for 16 × (n + 1) quadlets.

The transmit side watches the free space in its FIFO and the bytes still to fetch for the current descriptor. The receive side watches its FIFO fill level, the space left in the current host buffer, and a flag that says a whole packet is waiting. Each side normally waits for its threshold. It may ask early when the work left is small or urgent.

A request stays high until the bus grants it. The burst length is captured at the grant. No new request is raised until the owning DMA engine reports that the transaction is done.

Top module: `iso_busreq_ctrl`

## Requirements
- R1: After reset the control word reads 16'h7730. Its fields are: receive max-burst code in bits [15:12] (reset 7), transmit max-burst code in [11:8] (reset 7), transmit threshold code in [7:4] (reset 3), and receive threshold code in [3:0] (reset 0). Both requests are low.
- R2: A write to the control word takes effect at the next clock edge when link_en is low. The write is ignored, and the read-back value is unchanged, when link_en is high.
- R3: A max-burst code n limits a granted burst to 16 × (n + 1) quadlets, from 16 (n = 0) up to 256 (n = 15).
- R4: The transmit engine requests when its FIFO free space is at least 16 × (threshold code + 1) quadlets.
- R5: The transmit engine also requests early when the quadlets still to fetch are fewer than the FIFO free space. The quadlets still to fetch are the byte count rounded up to whole quadlets.
- R6: The receive engine requests when its FIFO holds at least 16 × (threshold code + 1) quadlets.
- R7: The receive engine also requests early in two cases: when the FIFO fill exceeds the space left in the host buffer, or when pkt_ready is high.
- R8: The transmit burst is the minimum of the max burst, the FIFO free space and the quadlets still to fetch. The receive burst is the minimum of the max burst, the FIFO fill and the host buffer space.
- R9: A request rises one clock after its condition is seen. It then stays high, whatever the inputs do, until a grant arrives. The burst output takes the burst value computed at the grant edge and holds it until the next grant.
- R10: After a grant the request drops. It stays low until the done pulse for that transaction.
- R11: A request is never raised while the computed burst is zero. This covers an empty receive FIFO, a full transmit FIFO, no bytes left to fetch, and no host buffer space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Link enabled; blocks control-word writes |
| cfg_wr_en | input | 1 | Control-word write strobe |
| cfg_wr_data | input | 16 | Control-word write value |
| cfg_rd_data | output | 16 | Current control word |
| it_free | input | LVL_W | Transmit FIFO free space, quadlets |
| it_remain_bytes | input | REM_W | Bytes still to fetch for the current descriptor |
| it_grant | input | 1 | Bus grant pulse for the transmit engine |
| it_done | input | 1 | Transmit transaction finished |
| it_req | output | 1 | Transmit bus request |
| it_burst | output | 9 | Transmit burst length, quadlets |
| ir_fill | input | LVL_W | Receive FIFO fill level, quadlets |
| ir_buf_space | input | LVL_W | Space left in the current host buffer, quadlets |
| ir_pkt_ready | input | 1 | A complete packet is in the receive FIFO |
| ir_grant | input | 1 | Bus grant pulse for the receive engine |
| ir_done | input | 1 | Receive transaction finished |
| ir_req | output | 1 | Receive bus request |
| ir_burst | output | 9 | Receive burst length, quadlets |

## Verification
The vector table drives both engines together with levels chosen to tell the request paths apart:
- levels that meet the threshold exactly, and levels one quadlet below it, separate a `>=` compare from a `>` compare;
- levels below the threshold that still fire early isolate the short-fetch path, the buffer-overrun path and the packet-ready path;
- candidates of zero show that a zero burst suppresses the request even when an early condition holds.

Burst results are picked so that each of the three minimum operands wins in some vector. Byte counts of 155 and 157 pin down round-up to quadlets. Directed tests then cover:
- changing the codes, including the 16- and 256-quadlet extremes, and a write blocked while the link is enabled;
- inputs that change while a request waits, which shows that the request is held and that the burst is captured at the grant.

// File: rtl/iso_busreq_pkg.sv
package iso_busreq_pkg;

    localparam int CODE_W  = 4;
    localparam int UNIT_SH = 4;                       // 16 quadlets per code step
    localparam int BURST_W = CODE_W + UNIT_SH + 1;    // holds 16*(15+1) = 256

    typedef struct packed {
        logic [CODE_W-1:0] rx_burst_code;
        logic [CODE_W-1:0] tx_burst_code;
        logic [CODE_W-1:0] tx_thr_code;
        logic [CODE_W-1:0] rx_thr_code;
    } iso_ctl_t;

    localparam iso_ctl_t CTL_RESET = '{
        rx_burst_code: 4'd7,
        tx_burst_code: 4'd7,
        tx_thr_code:   4'd3,
        rx_thr_code:   4'd0
    };

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_REQ  = 2'd1,
        ENG_BUSY = 2'd2
    } eng_state_t;

    // Quadlet count for a 4-bit code: 16 * (n + 1)
    function automatic logic [BURST_W-1:0] code_to_quads(input logic [CODE_W-1:0] n);
        logic [BURST_W-1:0] q;
        q = (BURST_W'(n) + BURST_W'(1)) << UNIT_SH;
        return q;
    endfunction

endpackage

// File: rtl/iso_ctl_reg.sv
module iso_ctl_reg
    import iso_busreq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     link_en,
    input  logic     wr_en,
    input  iso_ctl_t wr_data,
    output iso_ctl_t ctl
);

    iso_ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else if (wr_en && !link_en) begin
            ctl_q <= wr_data;
        end
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/iso_tx_policy.sv
module iso_tx_policy
    import iso_busreq_pkg::*;
#(
    parameter int LVL_W  = 10,
    parameter int REM_W  = 16,
    parameter int CALC_W = 16
) (
    input  logic [CODE_W-1:0] burst_code,
    input  logic [CODE_W-1:0] thr_code,
    input  logic [LVL_W-1:0]  fifo_free,
    input  logic [REM_W-1:0]  remain_bytes,
    output logic              want,
    output logic [CALC_W-1:0] cand
);

    logic [REM_W:0]    bytes_rnd;
    logic [CALC_W-1:0] remain_q;
    logic [CALC_W-1:0] free_w;
    logic [CALC_W-1:0] max_w;
    logic [CALC_W-1:0] thr_w;
    logic [CALC_W-1:0] lo;

    always_comb begin
        bytes_rnd = {1'b0, remain_bytes} + (REM_W+1)'(3);
        remain_q  = CALC_W'(bytes_rnd[REM_W:2]);
        free_w    = CALC_W'(fifo_free);
        max_w     = CALC_W'(code_to_quads(burst_code));
        thr_w     = CALC_W'(code_to_quads(thr_code));

        lo   = (max_w < free_w) ? max_w : free_w;
        cand = (remain_q < lo) ? remain_q : lo;

        want = (free_w >= thr_w) || (remain_q < free_w);
    end

endmodule

// File: rtl/iso_rx_policy.sv
module iso_rx_policy
    import iso_busreq_pkg::*;
#(
    parameter int LVL_W  = 10,
    parameter int CALC_W = 16
) (
    input  logic [CODE_W-1:0] burst_code,
    input  logic [CODE_W-1:0] thr_code,
    input  logic [LVL_W-1:0]  fifo_fill,
    input  logic [LVL_W-1:0]  buf_space,
    input  logic              pkt_ready,
    output logic              want,
    output logic [CALC_W-1:0] cand
);

    logic [CALC_W-1:0] fill_w;
    logic [CALC_W-1:0] space_w;
    logic [CALC_W-1:0] max_w;
    logic [CALC_W-1:0] thr_w;
    logic [CALC_W-1:0] lo;

    always_comb begin
        fill_w  = CALC_W'(fifo_fill);
        space_w = CALC_W'(buf_space);
        max_w   = CALC_W'(code_to_quads(burst_code));
        thr_w   = CALC_W'(code_to_quads(thr_code));

        lo   = (max_w < fill_w) ? max_w : fill_w;
        cand = (space_w < lo) ? space_w : lo;

        want = (fill_w >= thr_w) || (fill_w > space_w) || pkt_ready;
    end

endmodule

// File: rtl/iso_req_engine.sv
module iso_req_engine
    import iso_busreq_pkg::*;
#(
    parameter int CALC_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               want,
    input  logic [CALC_W-1:0]  cand,
    input  logic               grant,
    input  logic               done,
    output logic               req,
    output logic [BURST_W-1:0] burst
);

    eng_state_t         state;
    logic [BURST_W-1:0] burst_q;
    logic               cand_nz;

    assign cand_nz = (cand != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ENG_IDLE;
            burst_q <= '0;
        end else begin
            case (state)
                ENG_IDLE: if (want && cand_nz) state <= ENG_REQ;
                ENG_REQ: begin
                    if (grant) begin
                        state   <= ENG_BUSY;
                        burst_q <= BURST_W'(cand);
                    end
                end
                ENG_BUSY: if (done) state <= ENG_IDLE;
                default:  state <= ENG_IDLE;
            endcase
        end
    end

    assign req   = (state == ENG_REQ);
    assign burst = burst_q;

endmodule

// File: rtl/iso_busreq_ctrl.sv
module iso_busreq_ctrl
    import iso_busreq_pkg::*;
#(
    parameter int LVL_W = 10,
    parameter int REM_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               link_en,
    input  logic               cfg_wr_en,
    input  logic [15:0]        cfg_wr_data,
    output logic [15:0]        cfg_rd_data,
    input  logic [LVL_W-1:0]   it_free,
    input  logic [REM_W-1:0]   it_remain_bytes,
    input  logic               it_grant,
    input  logic               it_done,
    output logic               it_req,
    output logic [BURST_W-1:0] it_burst,
    input  logic [LVL_W-1:0]   ir_fill,
    input  logic [LVL_W-1:0]   ir_buf_space,
    input  logic               ir_pkt_ready,
    input  logic               ir_grant,
    input  logic               ir_done,
    output logic               ir_req,
    output logic [BURST_W-1:0] ir_burst
);

    localparam int W1     = (LVL_W > REM_W) ? LVL_W : REM_W;
    localparam int CALC_W = (W1 > BURST_W) ? W1 : BURST_W;

    iso_ctl_t          ctl;
    logic              tx_want, rx_want;
    logic [CALC_W-1:0] tx_cand, rx_cand;

    iso_ctl_reg u_ctl (
        .clk     (clk),
        .rst     (rst),
        .link_en (link_en),
        .wr_en   (cfg_wr_en),
        .wr_data (iso_ctl_t'(cfg_wr_data)),
        .ctl     (ctl)
    );

    assign cfg_rd_data = ctl;

    iso_tx_policy #(.LVL_W(LVL_W), .REM_W(REM_W), .CALC_W(CALC_W)) u_tx_pol (
        .burst_code   (ctl.tx_burst_code),
        .thr_code     (ctl.tx_thr_code),
        .fifo_free    (it_free),
        .remain_bytes (it_remain_bytes),
        .want         (tx_want),
        .cand         (tx_cand)
    );

    iso_rx_policy #(.LVL_W(LVL_W), .CALC_W(CALC_W)) u_rx_pol (
        .burst_code (ctl.rx_burst_code),
        .thr_code   (ctl.rx_thr_code),
        .fifo_fill  (ir_fill),
        .buf_space  (ir_buf_space),
        .pkt_ready  (ir_pkt_ready),
        .want       (rx_want),
        .cand       (rx_cand)
    );

    iso_req_engine #(.CALC_W(CALC_W)) u_tx_eng (
        .clk   (clk),
        .rst   (rst),
        .want  (tx_want),
        .cand  (tx_cand),
        .grant (it_grant),
        .done  (it_done),
        .req   (it_req),
        .burst (it_burst)
    );

    iso_req_engine #(.CALC_W(CALC_W)) u_rx_eng (
        .clk   (clk),
        .rst   (rst),
        .want  (rx_want),
        .cand  (rx_cand),
        .grant (ir_grant),
        .done  (ir_done),
        .req   (ir_req),
        .burst (ir_burst)
    );

endmodule

module iso_busreq_ctrl_chk
    import iso_busreq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               link_en,
    input logic               cfg_wr_en,
    input logic [15:0]        cfg_rd_data,
    input logic               it_grant,
    input logic               it_req,
    input logic [BURST_W-1:0] it_burst,
    input logic               ir_grant,
    input logic               ir_req,
    input logic [BURST_W-1:0] ir_burst
);

    // R2
    cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (link_en && cfg_wr_en) |=> $stable(cfg_rd_data));

    // R9
    it_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (it_req && !it_grant) |=> it_req);

    // R9
    ir_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ir_req && !ir_grant) |=> ir_req);

    // R10
    it_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (it_req && it_grant) |=> !it_req);

    // R10
    ir_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ir_req && ir_grant) |=> !ir_req);

    // R9
    it_burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(it_req && it_grant) |=> $stable(it_burst));

    // R9
    ir_burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(ir_req && ir_grant) |=> $stable(ir_burst));

    // R11
    it_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (it_req && it_grant) |=> (it_burst != '0));

    // R11
    ir_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (ir_req && ir_grant) |=> (ir_burst != '0));

    // R3
    burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (it_burst <= BURST_W'(256)) && (ir_burst <= BURST_W'(256)));

endmodule

bind iso_busreq_ctrl iso_busreq_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .link_en     (link_en),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_rd_data (cfg_rd_data),
    .it_grant    (it_grant),
    .it_req      (it_req),
    .it_burst    (it_burst),
    .ir_grant    (ir_grant),
    .ir_req      (ir_req),
    .ir_burst    (ir_burst)
);

// File: tb/iso_busreq_ctrl_bench.sv
module iso_busreq_ctrl_bench;

    localparam int LVL_W = 10;
    localparam int REM_W = 16;

    typedef struct packed {
        logic [9:0]  free;
        logic [15:0] rem;
        logic [9:0]  fill;
        logic [9:0]  bsp;
        logic        pkt;
        logic        it_r;
        logic [8:0]  it_b;
        logic        ir_r;
        logic [8:0]  ir_b;
    } vec_t;

    // default codes: max burst 128 both, tx threshold 64, rx threshold 16
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{10'd100, 16'd2000, 10'd20,  10'd1000, 1'b0, 1'b1, 9'd100, 1'b1, 9'd20 },  // R4 R6
        '{10'd40,  16'd4000, 10'd10,  10'd1000, 1'b0, 1'b0, 9'd0,   1'b0, 9'd0  },  // below both
        '{10'd40,  16'd80,   10'd10,  10'd6,    1'b0, 1'b1, 9'd20,  1'b1, 9'd6  },  // R5 R7 early
        '{10'd300, 16'd4000, 10'd10,  10'd1000, 1'b1, 1'b1, 9'd128, 1'b1, 9'd10 },  // R8 cap, R7 pkt
        '{10'd0,   16'd100,  10'd0,   10'd100,  1'b1, 1'b0, 9'd0,   1'b0, 9'd0  },  // R11
        '{10'd50,  16'd0,    10'd200, 10'd1000, 1'b0, 1'b0, 9'd0,   1'b1, 9'd128},  // R11 tx, R8 rx
        '{10'd40,  16'd157,  10'd15,  10'd15,   1'b0, 1'b0, 9'd0,   1'b0, 9'd0  },  // R5 rounding
        '{10'd40,  16'd155,  10'd10,  10'd0,    1'b1, 1'b1, 9'd39,  1'b0, 9'd0  },  // R5 R11
        '{10'd64,  16'd4000, 10'd16,  10'd1000, 1'b0, 1'b1, 9'd64,  1'b1, 9'd16 },  // R4 R6 exact
        '{10'd63,  16'd4000, 10'd5,   10'd5,    1'b0, 1'b0, 9'd0,   1'b0, 9'd0  }   // R4 R6 below
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             link_en = 1'b0;
    logic             cfg_wr_en = 1'b0;
    logic [15:0]      cfg_wr_data = '0;
    logic [15:0]      cfg_rd_data;
    logic [LVL_W-1:0] it_free = '0;
    logic [REM_W-1:0] it_remain_bytes = '0;
    logic             it_grant = 1'b0;
    logic             it_done = 1'b0;
    logic             it_req;
    logic [8:0]       it_burst;
    logic [LVL_W-1:0] ir_fill = '0;
    logic [LVL_W-1:0] ir_buf_space = '0;
    logic             ir_pkt_ready = 1'b0;
    logic             ir_grant = 1'b0;
    logic             ir_done = 1'b0;
    logic             ir_req;
    logic [8:0]       ir_burst;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    iso_busreq_ctrl #(.LVL_W(LVL_W), .REM_W(REM_W)) u_iso_busreq_ctrl (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        it_free = '0; it_remain_bytes = '0;
        ir_fill = '0; ir_buf_space = '0; ir_pkt_ready = 1'b0;
    endtask

    task automatic apply_vec(input vec_t v, input int idx);
        it_free = v.free; it_remain_bytes = v.rem;
        ir_fill = v.fill; ir_buf_space = v.bsp; ir_pkt_ready = v.pkt;
        tick();
        chk($sformatf("R4/R5/R11 it_req vec %0d", idx), 32'(it_req), 32'(v.it_r));
        chk($sformatf("R6/R7/R11 ir_req vec %0d", idx), 32'(ir_req), 32'(v.ir_r));
        it_grant = v.it_r;
        ir_grant = v.ir_r;
        tick();
        it_grant = 1'b0;
        ir_grant = 1'b0;
        if (v.it_r) chk($sformatf("R3/R8 it_burst vec %0d", idx), 32'(it_burst), 32'(v.it_b));
        if (v.ir_r) chk($sformatf("R3/R8 ir_burst vec %0d", idx), 32'(ir_burst), 32'(v.ir_b));
        tick();
        tick();
        chk($sformatf("R10 it_req in flight vec %0d", idx), 32'(it_req), 32'(0));
        chk($sformatf("R10 ir_req in flight vec %0d", idx), 32'(ir_req), 32'(0));
        it_done = 1'b1; ir_done = 1'b1;
        idle_inputs();
        tick();
        it_done = 1'b0; ir_done = 1'b0;
        tick();
    endtask

    task automatic write_cfg(input logic [15:0] val);
        cfg_wr_data = val;
        cfg_wr_en = 1'b1;
        tick();
        cfg_wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 reset control word", 32'(cfg_rd_data), 32'h7730);
        chk("R1 reset it_req", 32'(it_req), 0);
        chk("R1 reset ir_req", 32'(ir_req), 0);

        for (int i = 0; i < NV; i++) apply_vec(VECS[i], i);

        // R9: request held while inputs fall below threshold; burst sampled at grant
        it_free = 10'd100; it_remain_bytes = 16'd4000;
        tick();
        chk("R9 it_req raised", 32'(it_req), 1);
        it_free = 10'd40;
        tick(); tick(); tick();
        chk("R9 it_req held without grant", 32'(it_req), 1);
        it_grant = 1'b1;
        tick();
        it_grant = 1'b0;
        chk("R9 it_burst sampled at grant", 32'(it_burst), 40);
        chk("R10 it_req dropped after grant", 32'(it_req), 0);
        it_done = 1'b1; idle_inputs();
        tick();
        it_done = 1'b0;
        tick();

        // R2: writes ignored while link enabled
        link_en = 1'b1;
        write_cfg(16'hFFFF);
        chk("R2 write ignored with link enabled", 32'(cfg_rd_data), 32'h7730);
        link_en = 1'b0;
        write_cfg(16'hFF00);
        chk("R2 write accepted with link disabled", 32'(cfg_rd_data), 32'hFF00);

        // R3 largest burst 256; thresholds now 16
        apply_vec('{10'd300, 16'd4000, 10'd400, 10'd1000, 1'b0, 1'b1, 9'd256, 1'b1, 9'd256}, 100);
        // R4 R6 at threshold code 0
        apply_vec('{10'd16, 16'd4000, 10'd16, 10'd1000, 1'b0, 1'b1, 9'd16, 1'b1, 9'd16}, 101);
        apply_vec('{10'd15, 16'd4000, 10'd15, 10'd1000, 1'b0, 1'b0, 9'd0, 1'b0, 9'd0}, 102);

        // R3 smallest burst 16
        write_cfg(16'h0000);
        chk("R2 zero write accepted", 32'(cfg_rd_data), 0);
        apply_vec('{10'd300, 16'd4000, 10'd400, 10'd1000, 1'b0, 1'b1, 9'd16, 1'b1, 9'd16}, 103);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule